// File: doc/BRIEF.md
# Cacheability Attribute Priority Resolver

For every CPU access, this block decides whether the access may use the cache. If it may not, the block decides whether the access goes out on the external bus or is served through the line-fill buffer path. Four programmable address regions are checked in a fixed order: an on-chip RAM window, an on-chip ROM window, and two general access-control windows. If none of them claims the address, a default mode from the cache control register decides. Accesses to CPU-space registers (control-register moves) are always treated as inhibited, whatever the regions say.

The decision is formed combinationally from the request and the current region settings. It is then captured in one register stage, so the result appears exactly one cycle after the accepted request. Software programs the regions through a small write port that selects a region (or the control register) and a field. The cache array itself lies outside this block.

Top module: `cache_attr_resolver`

## Requirements
- R1: After reset, `rsp_valid` is 0, every region is invalid and the default mode is inhibited. A request made before any programming therefore reports not cacheable, external, and winner code 4.
- R2: Region k matches when its valid bit is set and `(req_addr & mask) == (base & mask)`. Address and base bits outside the mask are ignored. A region whose valid bit is clear never matches and is never reported as the winner.
- R3: When several regions match, the lowest index wins. The order is RAM window (code 0), then ROM window (code 1), then control window A (code 2), then control window B (code 3). The winner's inhibit bit decides cacheability.
- R4: When no valid region matches, the default-inhibit bit of the control register decides cacheability, and `rsp_win` is 4.
- R5: When the winning region's inhibit bit is 1, the access is not cacheable and, unless R8 applies, `rsp_ext` is 1.
- R6: An inhibited write always gives `rsp_ext`=1 and `rsp_fbuf`=0.
- R7: A request with `req_cpu_space`=1 is reported as not cacheable, external and winner code 5, whatever the region matches are.
- R8: `rsp_fbuf`=1 (and `rsp_ext`=0) exactly when all of these hold: the access is inhibited, the fill-buffer enable is set, `req_instr`=1, `req_write`=0, `req_tt`=0, and `req_cpu_space`=0.
- R9: For every response, exactly one of `rsp_cacheable`, `rsp_ext` and `rsp_fbuf` is 1. A cacheable access gives `rsp_ext`=0 and `rsp_fbuf`=0.
- R10: `rsp_valid` is 1 in the cycle after a cycle with `req_valid`=1, and 0 after a cycle without one. The response fields belong to that request.
- R11: A write with `cfg_we`=1 lands at the clock edge and applies to requests presented from the next cycle on. `cfg_sel` 0 to 3 picks a region and `cfg_sel` 4 picks the control register. The `cfg_fld` codes are: 0 writes the base, 1 writes the mask, and 2 writes the attributes. For a region, the attribute bits are bit 0 = valid and bit 1 = inhibit. For the control register, they are bit 0 = default-inhibit and bit 1 = fill-buffer enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Target: region 0-3 or control register 4 |
| cfg_fld | input | 2 | Field: 0 base, 1 mask, 2 attributes |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Access address |
| req_instr | input | 1 | 1 = instruction access, 0 = data access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tt | input | 2 | Transfer-type code, 0 = normal |
| req_cpu_space | input | 1 | CPU-space register access |
| rsp_valid | output | 1 | Decision valid (one cycle after request) |
| rsp_cacheable | output | 1 | Access may use the cache |
| rsp_ext | output | 1 | External bus transfer required |
| rsp_fbuf | output | 1 | Inhibited read routed to the fill-buffer path |
| rsp_win | output | 3 | Deciding source: 0-3 region, 4 default, 5 CPU space |

## Verification
Every decision passes through exactly one register, so all response fields for a request presented in cycle n are due in cycle n+1. The bench drives each request on a falling edge and compares all four fields and `rsp_valid` on the following falling edge, one cycle later. A configuration write is driven on a falling edge and is followed directly by requests on the next falling edge, which tests that a write applies from the next cycle on. The sweep programs the regions so that each one tests a single address bit. It then steps through every valid/inhibit pattern, both default modes and both fill-buffer settings, and every hit set and access type, with each expected result computed by the bench from the requirements.

// File: rtl/cattr_pkg.sv
package cattr_pkg;

  // Field codes of the configuration write port
  localparam logic [1:0] FLD_BASE = 2'd0;
  localparam logic [1:0] FLD_MASK = 2'd1;
  localparam logic [1:0] FLD_ATTR = 2'd2;

  typedef struct packed {
    logic cacheable;
    logic ext;
    logic fbuf;
  } route_t;

  // Routing of an access once its inhibit status is known
  function automatic route_t route_of(input logic inhibit,
                                      input logic is_write,
                                      input logic is_instr,
                                      input logic tt_zero,
                                      input logic fbuf_en,
                                      input logic cpu);
    route_t r;
    logic   fb;
    fb          = inhibit & fbuf_en & is_instr & ~is_write & tt_zero & ~cpu;
    r.cacheable = ~inhibit;
    r.fbuf      = fb;
    r.ext       = inhibit & ~fb;
    return r;
  endfunction

endpackage

// File: rtl/cattr_cfg_regs.sv
module cattr_cfg_regs
  import cattr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NREG   = 4,
  localparam int unsigned SEL_W = $clog2(NREG + 1)
)(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [SEL_W-1:0]               cfg_sel,
  input  logic [1:0]                     cfg_fld,
  input  logic [ADDR_W-1:0]              cfg_wdata,
  output logic [NREG-1:0][ADDR_W-1:0]    rg_base,
  output logic [NREG-1:0][ADDR_W-1:0]    rg_mask,
  output logic [NREG-1:0]                rg_valid,
  output logic [NREG-1:0]                rg_inhib,
  output logic                           dflt_inhibit,
  output logic                           fbuf_en
);

  for (genvar g = 0; g < NREG; g++) begin : g_rg
    logic sel_hit;
    assign sel_hit = cfg_we && (cfg_sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rg_base[g]  <= '0;
        rg_mask[g]  <= '0;
        rg_valid[g] <= 1'b0;
        rg_inhib[g] <= 1'b0;
      end else if (sel_hit) begin
        case (cfg_fld)
          FLD_BASE: rg_base[g] <= cfg_wdata;
          FLD_MASK: rg_mask[g] <= cfg_wdata;
          FLD_ATTR: begin
            rg_valid[g] <= cfg_wdata[0];
            rg_inhib[g] <= cfg_wdata[1];
          end
          default: ;
        endcase
      end
    end
  end

  logic ctl_hit;
  assign ctl_hit = cfg_we && (cfg_sel == SEL_W'(NREG)) && (cfg_fld == FLD_ATTR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dflt_inhibit <= 1'b1;
      fbuf_en      <= 1'b0;
    end else if (ctl_hit) begin
      dflt_inhibit <= cfg_wdata[0];
      fbuf_en      <= cfg_wdata[1];
    end
  end

endmodule

// File: rtl/cattr_region_match.sv
module cattr_region_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NREG   = 4
)(
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NREG-1:0][ADDR_W-1:0] rg_base,
  input  logic [NREG-1:0][ADDR_W-1:0] rg_mask,
  input  logic [NREG-1:0]             rg_valid,
  output logic [NREG-1:0]             hit
);

  function automatic logic masked_eq(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b,
                                     input logic [ADDR_W-1:0] m);
    return ((a & m) == (b & m));
  endfunction

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign hit[g] = rg_valid[g] && masked_eq(addr, rg_base[g], rg_mask[g]);
  end

endmodule

// File: rtl/cattr_decide.sv
module cattr_decide
  import cattr_pkg::*;
#(
  parameter int unsigned NREG  = 4,
  parameter int unsigned TT_W  = 2,
  localparam int unsigned WIN_W = $clog2(NREG + 2)
)(
  input  logic [NREG-1:0]  hit,
  input  logic [NREG-1:0]  rg_inhib,
  input  logic             dflt_inhibit,
  input  logic             fbuf_en,
  input  logic             is_instr,
  input  logic             is_write,
  input  logic [TT_W-1:0]  tt,
  input  logic             cpu,
  output logic [WIN_W-1:0] win,
  output logic             inhibit,
  output route_t           route
);

  always_comb begin
    win     = WIN_W'(NREG);
    inhibit = dflt_inhibit;
    // walk from lowest priority up so the lowest index ends as winner
    for (int k = NREG - 1; k >= 0; k--) begin
      if (hit[k]) begin
        win     = WIN_W'(k);
        inhibit = rg_inhib[k];
      end
    end
    if (cpu) begin
      win     = WIN_W'(NREG + 1);
      inhibit = 1'b1;
    end
    route = route_of(inhibit, is_write, is_instr, (tt == '0), fbuf_en, cpu);
  end

endmodule

// File: rtl/cache_attr_resolver.sv
module cache_attr_resolver
  import cattr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NREG   = 4,
  parameter int unsigned TT_W   = 2,
  localparam int unsigned SEL_W = $clog2(NREG + 1),
  localparam int unsigned WIN_W = $clog2(NREG + 2)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [1:0]        cfg_fld,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_instr,
  input  logic              req_write,
  input  logic [TT_W-1:0]   req_tt,
  input  logic              req_cpu_space,
  output logic              rsp_valid,
  output logic              rsp_cacheable,
  output logic              rsp_ext,
  output logic              rsp_fbuf,
  output logic [WIN_W-1:0]  rsp_win
);

  logic [NREG-1:0][ADDR_W-1:0] rg_base;
  logic [NREG-1:0][ADDR_W-1:0] rg_mask;
  logic [NREG-1:0]             rg_valid;
  logic [NREG-1:0]             rg_inhib;
  logic                        dflt_inhibit;
  logic                        fbuf_en;
  logic [NREG-1:0]             region_hit;
  logic [WIN_W-1:0]            dec_win;
  logic                        dec_inhibit;
  route_t                      dec_route;

  cattr_cfg_regs #(.ADDR_W(ADDR_W), .NREG(NREG)) i_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_fld      (cfg_fld),
    .cfg_wdata    (cfg_wdata),
    .rg_base      (rg_base),
    .rg_mask      (rg_mask),
    .rg_valid     (rg_valid),
    .rg_inhib     (rg_inhib),
    .dflt_inhibit (dflt_inhibit),
    .fbuf_en      (fbuf_en)
  );

  cattr_region_match #(.ADDR_W(ADDR_W), .NREG(NREG)) i_match (
    .addr     (req_addr),
    .rg_base  (rg_base),
    .rg_mask  (rg_mask),
    .rg_valid (rg_valid),
    .hit      (region_hit)
  );

  cattr_decide #(.NREG(NREG), .TT_W(TT_W)) i_decide (
    .hit          (region_hit),
    .rg_inhib     (rg_inhib),
    .dflt_inhibit (dflt_inhibit),
    .fbuf_en      (fbuf_en),
    .is_instr     (req_instr),
    .is_write     (req_write),
    .tt           (req_tt),
    .cpu          (req_cpu_space),
    .win          (dec_win),
    .inhibit      (dec_inhibit),
    .route        (dec_route)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_cacheable <= 1'b0;
      rsp_ext       <= 1'b0;
      rsp_fbuf      <= 1'b0;
      rsp_win       <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_cacheable <= dec_route.cacheable;
        rsp_ext       <= dec_route.ext;
        rsp_fbuf      <= dec_route.fbuf;
        rsp_win       <= dec_win;
      end
    end
  end

endmodule

// File: rtl/cattr_checker.sv
module cattr_checker #(
  parameter int unsigned NREG  = 4,
  parameter int unsigned TT_W  = 2,
  parameter int unsigned WIN_W = 3
)(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_instr,
  input logic             req_write,
  input logic [TT_W-1:0]  req_tt,
  input logic             req_cpu_space,
  input logic             rsp_valid,
  input logic             rsp_cacheable,
  input logic             rsp_ext,
  input logic             rsp_fbuf,
  input logic [WIN_W-1:0] rsp_win,
  input logic [NREG-1:0]  rg_valid,
  input logic             fbuf_en
);

  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r10_idle_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r9_one_route: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_cacheable, rsp_ext, rsp_fbuf}) == 1);

  a_r6_write_not_fbuf: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> !rsp_fbuf && (rsp_cacheable || rsp_ext));

  a_r7_cpu_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_cpu_space |=> !rsp_cacheable && rsp_ext && rsp_win == WIN_W'(NREG + 1));

  a_r8_fbuf_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !(req_instr && !req_write && req_tt == '0 && fbuf_en && !req_cpu_space)
    |=> !rsp_fbuf);

  a_r3_win_range: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_win <= WIN_W'(NREG + 1));

  for (genvar g = 0; g < NREG; g++) begin : g_inv
    a_r2_invalid_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !rg_valid[g] && !req_cpu_space |=> rsp_win != WIN_W'(g));
  end

endmodule

bind cache_attr_resolver cattr_checker #(.NREG(NREG), .TT_W(TT_W), .WIN_W(WIN_W)) i_cattr_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_instr     (req_instr),
  .req_write     (req_write),
  .req_tt        (req_tt),
  .req_cpu_space (req_cpu_space),
  .rsp_valid     (rsp_valid),
  .rsp_cacheable (rsp_cacheable),
  .rsp_ext       (rsp_ext),
  .rsp_fbuf      (rsp_fbuf),
  .rsp_win       (rsp_win),
  .rg_valid      (rg_valid),
  .fbuf_en       (fbuf_en)
);

// File: tb/test_cache_attr_resolver.sv
module test_cache_attr_resolver;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [1:0]  cfg_fld = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_instr = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_tt = '0;
  logic        req_cpu_space = 1'b0;
  logic        rsp_valid, rsp_cacheable, rsp_ext, rsp_fbuf;
  logic [2:0]  rsp_win;

  int n_chk = 0;
  int n_err = 0;

  // bench-side view of the programmed state
  logic [3:0] m_inh = '0;
  logic       m_dflt = 1'b1;
  logic       m_fb = 1'b0;

  always #2.5 clk = ~clk;

  cache_attr_resolver i_cache_attr_resolver (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_fld(cfg_fld),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_instr(req_instr), .req_write(req_write), .req_tt(req_tt),
    .req_cpu_space(req_cpu_space), .rsp_valid(rsp_valid), .rsp_cacheable(rsp_cacheable),
    .rsp_ext(rsp_ext), .rsp_fbuf(rsp_fbuf), .rsp_win(rsp_win)
  );

  // expected {valid, cacheable, ext, fbuf, win[2:0]}
  function automatic logic [6:0] model(input logic [3:0] hits, input logic instr,
                                       input logic wr, input logic [1:0] tt, input logic cpu);
    int   w = 4;
    logic inh = m_dflt;
    logic fb;
    for (int k = 3; k >= 0; k--)
      if (hits[k]) begin w = k; inh = m_inh[k]; end
    if (cpu) begin w = 5; inh = 1'b1; end
    fb = inh && m_fb && instr && !wr && (tt == 2'd0) && !cpu;
    return {1'b1, !inh, inh && !fb, fb, 3'(w)};
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b (v,c,e,f,win)", tag, act, exp);
    end
  endtask

  // call at a falling edge; returns at the next falling edge
  task automatic cfg_write(input int sel, input logic [1:0] fld, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_fld = fld; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_req(input logic [31:0] a, input logic instr, input logic wr,
                        input logic [1:0] tt, input logic cpu, input logic [3:0] hits,
                        input string tag);
    logic [6:0] exp;
    exp = model(hits, instr, wr, tt, cpu);
    req_valid = 1'b1; req_addr = a; req_instr = instr; req_write = wr;
    req_tt = tt; req_cpu_space = cpu;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {rsp_valid, rsp_cacheable, rsp_ext, rsp_fbuf, rsp_win}, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {rsp_valid, 6'd0}, 7'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {rsp_valid, 6'd0}, 7'd0);
    do_req(32'h0000_1000, 1'b0, 1'b0, 2'd0, 1'b0, 4'b0000, "R1 default inhibited");
    // R10: no request -> no response
    @(negedge clk);
    check("R10 idle", {rsp_valid, 6'd0}, 7'd0);

    // R11/R4: default becomes cacheable, effective next cycle
    cfg_write(4, 2'd2, 32'h0); m_dflt = 1'b0;
    do_req(32'h0000_1000, 1'b0, 1'b0, 2'd0, 1'b0, 4'b0000, "R11 default write");

    // R2: multi-bit mask, bits outside mask ignored
    cfg_write(0, 2'd0, 32'h2FFF_FFFF);
    cfg_write(0, 2'd1, 32'hF000_0000);
    do_req(32'h2ABC_DEF0, 1'b0, 1'b0, 2'd0, 1'b0, 4'b0000, "R2 invalid no match");
    cfg_write(0, 2'd2, 32'h3); m_inh[0] = 1'b1;
    do_req(32'h2ABC_DEF0, 1'b0, 1'b0, 2'd0, 1'b0, 4'b0001, "R2 masked match");
    do_req(32'h3ABC_DEF0, 1'b0, 1'b0, 2'd0, 1'b0, 4'b0000, "R2 masked miss");
    // R5: inhibited data read goes external
    do_req(32'h2000_0000, 1'b0, 1'b0, 2'd0, 1'b0, 4'b0001, "R5 inhibited read");

    // sweep setup: region k tests address bit k+4; base carries junk outside mask
    for (int k = 0; k < 4; k++) begin
      cfg_write(k, 2'd0, 32'hA500_0000 | (32'h10 << k));
      cfg_write(k, 2'd1, 32'h10 << k);
    end

    for (int fb = 0; fb < 2; fb++)
      for (int d = 0; d < 2; d++)
        for (int v = 0; v < 16; v++)
          for (int h = 0; h < 16; h++) begin
            for (int k = 0; k < 4; k++) begin
              cfg_write(k, 2'd2, {30'd0, h[k], v[k]});
              m_inh[k] = h[k];
            end
            cfg_write(4, 2'd2, {30'd0, fb[0], d[0]});
            m_fb = fb[0]; m_dflt = d[0];
            for (int nib = 0; nib < 16; nib++) begin
              logic [3:0] hs;
              logic [31:0] a;
              hs = 4'(nib) & 4'(v);
              a = 32'h1200_0003 | (32'(nib) << 4);
              for (int t = 0; t < 9; t++) begin
                logic       ins, wr, cpu, inh;
                logic [1:0] tt;
                string      tag;
                ins = (t < 8) ? t[0] : 1'b1;
                wr  = (t < 8) ? t[1] : 1'b0;
                tt  = (t < 8 && t[2]) ? 2'b10 : 2'b00;
                cpu = (t == 8);
                inh = (hs == 4'd0) ? d[0] : !model(hs, 1'b0, 1'b1, 2'd0, 1'b0)[5];
                if (cpu) tag = "R7 cpu space";
                else if (inh && ins && !wr) tag = "R8 fill buffer";
                else if (inh && wr) tag = "R6 inhibited write";
                else if (hs == 4'd0) tag = "R4 default";
                else if (!inh) tag = "R9 cacheable";
                else tag = "R3 priority";
                do_req(a, ins, wr, tt, cpu, hs, tag);
              end
            end
          end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule